// File: doc/BRIEF.md
# Address Range Breakpoint Counter

This block watches the processor's memory accesses and decides when to send the processor into debug mode. Two limit registers define an address window. Both bounds are inclusive. A 4-bit event selector chooses two things: which access types count, and how the latched address must sit relative to the window. A 24-bit occurrence counter is loaded with one less than the number of matching accesses wanted. It counts down on each match. When a match arrives while the counter already reads zero, the block issues a one-cycle debug-entry request.

A small register port takes the place of the debug serial link. Through it, software sets the limits and the event selector, and it loads, reads or clears the counter. It also reads a sticky flag that records a fired breakpoint, and clears that flag. After it changes a limit or the event selection, software writes the counter. That write re-arms the match logic, so events from before the write cannot affect the new setup.

Top module: `addr_range_bkpt`

## Requirements
- R1: After reset the counter, both limits, the event selector, the sticky flag and `debug_req` all read zero.
- R2: Register port select codes are 0 = upper limit, 1 = lower limit, 2 = event selector (bits 3:0), 3 = counter load, 4 = counter clear (data ignored), 5 = status (bit 0 = sticky flag). A write takes effect at the clock edge. `reg_rdata` shows the selected register combinationally, zero-extended. Code 3 and code 4 both read the counter.
- R3: Event selector bits 3:2 pick the address condition: 00 = lower ≤ addr ≤ upper, 01 = addr outside that window, 10 = addr ≤ upper, 11 = addr ≥ lower. Every comparison is unsigned and inclusive.
- R4: Event selector bits 1:0 pick the access type: 00 = none, 01 = read, 10 = write, 11 = read or write.
- R5: An access is latched on a clock edge where `acc_valid` is high. It is evaluated at the next edge, and `debug_req` is high in the cycle that follows that second edge.
- R6: Each qualifying event decrements a nonzero counter by one. A qualifying event that finds the counter at zero fires. A load of N-1 therefore fires on the N-th event.
- R7: Once the block fires it is disarmed, and further events are ignored. A counter load or clear re-arms it.
- R8: A counter load or clear in the same cycle as a qualifying event wins. The event is dropped, neither firing nor decrementing.
- R9: Firing sets the sticky flag. Writing status with bit 0 set clears the flag. If firing and clearing happen in the same cycle, the flag ends up set.
- R10: An event selector with bits 1:0 = 00, including 0000, never produces `debug_req`.
- R11: `debug_req` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Memory access strobe |
| acc_addr | input | AW | Access address |
| acc_rd | input | 1 | Access is a read |
| acc_wr | input | 1 | Access is a write |
| reg_we | input | 1 | Register port write enable |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Selected register value |
| debug_req | output | 1 | Debug-entry request pulse |

## Verification
The main sweep tries every one of the 16 event selector values against the same set of addresses. The set takes each limit, one address on either side of each limit, and the two extremes of the address space. Each address is tried as a read, a write and an access with neither flag. The limit-adjacent addresses catch a comparator that is exclusive instead of inclusive, or swapped. The three access kinds separate the type decodes. Directed sequences then test the count-down with a load of 2 and the disarm after firing, and they test a write and an event in the same cycle, for both the counter and the sticky flag.

// File: rtl/addr_range_bkpt.sv
module addr_range_bkpt #(
  parameter int AW = 16,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          debug_req
);
  localparam logic [2:0] SEL_HI = 3'd0, SEL_LO = 3'd1, SEL_EV = 3'd2,
                         SEL_CNT = 3'd3, SEL_CLR = 3'd4, SEL_STAT = 3'd5;

  logic [AW-1:0] hi_q, lo_q, addr_q;
  logic [3:0]    evsel_q;
  logic [CW-1:0] cnt_q;
  logic          vld_q, rd_q, wr_q, armed_q, sticky_q;
  logic          range_ok, type_ok;

  wire le_hi  = addr_q <= hi_q;
  wire ge_lo  = addr_q >= lo_q;
  wire cnt_wr = reg_we && (reg_sel == SEL_CNT || reg_sel == SEL_CLR);
  wire st_clr = reg_we && reg_sel == SEL_STAT && reg_wdata[0];

  always_comb begin
    case (evsel_q[3:2])
      2'b00:   range_ok = le_hi && ge_lo;
      2'b01:   range_ok = !(le_hi && ge_lo);
      2'b10:   range_ok = le_hi;
      default: range_ok = ge_lo;
    endcase
    case (evsel_q[1:0])
      2'b00:   type_ok = 1'b0;
      2'b01:   type_ok = rd_q;
      2'b10:   type_ok = wr_q;
      default: type_ok = rd_q || wr_q;
    endcase
  end

  wire event_ok = vld_q && type_ok && range_ok && armed_q && !cnt_wr;
  wire fire     = event_ok && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      vld_q <= acc_valid;
      rd_q  <= acc_valid && acc_rd;
      wr_q  <= acc_valid && acc_wr;
      if (acc_valid) addr_q <= acc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      evsel_q <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_HI) hi_q    <= reg_wdata[AW-1:0];
      if (reg_sel == SEL_LO) lo_q    <= reg_wdata[AW-1:0];
      if (reg_sel == SEL_EV) evsel_q <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      armed_q   <= 1'b1;
      debug_req <= 1'b0;
      sticky_q  <= 1'b0;
    end else begin
      debug_req <= fire;
      if (cnt_wr) begin
        cnt_q   <= (reg_sel == SEL_CNT) ? reg_wdata : '0;
        armed_q <= 1'b1;
      end else if (fire) begin
        armed_q <= 1'b0;
      end else if (event_ok) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (fire)        sticky_q <= 1'b1;
      else if (st_clr) sticky_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_HI:           reg_rdata = CW'(hi_q);
      SEL_LO:           reg_rdata = CW'(lo_q);
      SEL_EV:           reg_rdata = CW'(evsel_q);
      SEL_CNT, SEL_CLR: reg_rdata = cnt_q;
      SEL_STAT:         reg_rdata = CW'(sticky_q);
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/addr_range_bkpt_chk.sv
module addr_range_bkpt_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_sel,
  input logic [CW-1:0] reg_wdata,
  input logic          debug_req,
  input logic [CW-1:0] cnt_q,
  input logic          armed_q,
  input logic          sticky_q,
  input logic [3:0]    evsel_q
);
  wire cnt_wr = reg_we && (reg_sel == 3'd3 || reg_sel == 3'd4);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |=> !debug_req);
  a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |-> sticky_q);
  a_r6_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |-> $past(cnt_q) == '0);
  a_r6_no_increase: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> cnt_q <= $past(cnt_q));
  a_r7_load_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd3) |=> (cnt_q == $past(reg_wdata)) && armed_q);
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !debug_req);
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (evsel_q[1:0] == 2'b00) |=> !debug_req);
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |-> !armed_q || $past(cnt_wr));
endmodule

bind addr_range_bkpt addr_range_bkpt_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .debug_req(debug_req), .cnt_q(cnt_q),
  .armed_q(armed_q), .sticky_q(sticky_q), .evsel_q(evsel_q)
);

// File: tb/addr_range_bkpt_tb.sv
`timescale 1ns/1ps
module addr_range_bkpt_tb;
  localparam int AW = 16, CW = 24;
  localparam logic [AW-1:0] LO = 16'h0040, HI = 16'h0080;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_rd = 0, acc_wr = 0, reg_we = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0] reg_sel = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic debug_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_range_bkpt #(.AW(AW), .CW(CW)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [CW-1:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [CW-1:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic access(input logic [AW-1:0] a, input bit rd, input bit wr, output bit fired);
    acc_valid = 1; acc_addr = a; acc_rd = rd; acc_wr = wr;
    @(negedge clk);
    acc_valid = 0; acc_rd = 0; acc_wr = 0;
    @(negedge clk);
    fired = debug_req;
  endtask

  function automatic bit expect_hit(input logic [3:0] ev, input logic [AW-1:0] a, input bit rd, input bit wr);
    bit t, inr, r;
    inr = (a >= LO) && (a <= HI);
    case (ev[1:0])
      2'b00: t = 0;
      2'b01: t = rd;
      2'b10: t = wr;
      default: t = rd || wr;
    endcase
    case (ev[3:2])
      2'b00: r = inr;
      2'b01: r = !inr;
      2'b10: r = a <= HI;
      default: r = a >= LO;
    endcase
    return t && r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    bit f;
    logic [AW-1:0] addrs[8];
    addrs = '{LO - 16'd1, LO, LO + 16'd1, HI - 16'd1, HI, HI + 16'd1, 16'h0000, 16'hFFFF};
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      rd_reg(3'(s), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(debug_req == 0, "R1 reset debug_req", debug_req, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 readback
    wr_reg(3'd0, 24'hFFBEEF); rd_reg(3'd0, v);
    check(v == 24'h00BEEF, "R2 upper readback", v, 24'h00BEEF);
    wr_reg(3'd2, 24'h00003B); rd_reg(3'd2, v);
    check(v == 24'hB, "R2 selector readback", v, 24'hB);
    wr_reg(3'd3, 24'hABCDEF); rd_reg(3'd3, v);
    check(v == 24'hABCDEF, "R2 counter readback", v, 24'hABCDEF);
    wr_reg(3'd4, 24'h123456); rd_reg(3'd3, v);
    check(v == 0, "R2 counter clear", v, 0);

    wr_reg(3'd0, 24'(HI));
    wr_reg(3'd1, 24'(LO));

    // R3 R4 R10 sweep: every selector, boundary addresses, access kinds
    for (int ev = 0; ev < 16; ev++) begin
      wr_reg(3'd2, 24'(ev));
      for (int ai = 0; ai < 8; ai++) begin
        for (int k = 0; k < 3; k++) begin
          bit rd, wr, e;
          rd = (k == 0); wr = (k == 1);
          wr_reg(3'd3, 24'd0);
          access(addrs[ai], rd, wr, f);
          e = expect_hit(4'(ev), addrs[ai], rd, wr);
          check(f == e, (ev[1:0] == 0) ? "R10 disabled selector" : "R3 R4 R5 match decode", f, e);
        end
      end
      wr_reg(3'd5, 24'd1);
    end

    // R6 R7 count-down and disarm
    wr_reg(3'd2, 24'h3);
    wr_reg(3'd3, 24'd2);
    access(LO, 1, 0, f); rd_reg(3'd3, v);
    check(!f && v == 1, "R6 first event decrements", v, 1);
    access(HI, 0, 1, f); rd_reg(3'd3, v);
    check(!f && v == 0, "R6 second event decrements", v, 0);
    access(LO, 1, 0, f);
    check(f, "R6 fires on third event", f, 1);
    @(negedge clk);
    check(debug_req == 0, "R11 pulse one cycle", debug_req, 0);
    rd_reg(3'd5, v);
    check(v == 1, "R9 sticky set", v, 1);
    access(LO, 1, 0, f);
    check(!f, "R7 disarmed after fire", f, 0);
    wr_reg(3'd4, 24'd0);
    access(LO, 1, 0, f);
    check(f, "R7 clear re-arms", f, 1);
    wr_reg(3'd5, 24'd1); rd_reg(3'd5, v);
    check(v == 0, "R9 sticky cleared", v, 0);

    // R8 counter write beats event
    wr_reg(3'd3, 24'd2);
    acc_valid = 1; acc_addr = LO; acc_rd = 1;
    @(negedge clk);
    acc_valid = 0; acc_rd = 0;
    wr_reg(3'd3, 24'd5);
    rd_reg(3'd3, v);
    check(v == 5 && debug_req == 0, "R8 write wins over event", v, 5);

    // R9 fire beats sticky clear
    wr_reg(3'd3, 24'd0);
    acc_valid = 1; acc_addr = HI; acc_wr = 1;
    @(negedge clk);
    acc_valid = 0; acc_wr = 0;
    wr_reg(3'd5, 24'd1);
    check(debug_req == 1, "R9 fire in clear cycle", debug_req, 1);
    rd_reg(3'd5, v);
    check(v == 1, "R9 set wins over clear", v, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule